// File: doc/BRIEF.md
# Glitch-Free Clock Freeze Gate Bank

This block places one freeze gate between each free-running divided clock and the pad that carries it off the chip. Each channel has its own asynchronous run request. The request is synchronized into the fast source-clock domain. While the request is low, the channel's output is held low. The divider behind a gate is never stopped. A channel that is released therefore comes back on the same edges as the channels that were never frozen.

Every change to a gate's state waits for a fast-clock cycle in which the divided clock is low now and will still be low in the next cycle. A frozen clock is only ever caught after it has fallen by itself, and a released clock only ever starts at one of its own rising edges. The divider must present its current level (`div_cur`) and the level it will have in the next fast cycle (`div_nxt`). Each low phase must last at least two fast cycles. An active-low master reset disables the pad drivers at once and returns every gate to the running state.

Top module: `clk_freeze_gate`

## Requirements
- R1: Driving `run_req[i]` to 0 freezes channel i. Once the freeze takes effect, `out_val[i]` stays 0 while `div_cur[i]` keeps toggling, and the other channels are unaffected. Bit i of every vector belongs to channel i.
- R2: A freeze never shortens a high pulse. `out_val[i]` falls only in a cycle where `div_cur[i]` falls, so a pulse that has started always runs its full width.
- R3: After an unfreeze, `out_val[i]` first rises in a cycle where `div_cur[i]` rises from 0 to 1. No partial high pulse is produced.
- R4: While channel i runs, `out_val[i]` equals `div_cur[i]` in every cycle with no added delay, so it stays in phase with channels that were never frozen.
- R5: A channel's gate state changes only at a clock edge that ends a cycle with `div_cur[i]` = `div_nxt[i]` = 0. A request driven during cycle k can first be applied at edge k+SYNC_STAGES+1, where edge j+1 ends cycle j.
- R6: After reset is released, every channel runs (`out_val` = `div_cur`) with no request needed.
- R7: While `rst_n` is 0, `out_oe` is all zeros at once, without waiting for a clock edge, and every gate returns to the running state. While `rst_n` is 1, `out_oe` is all ones.
- R8: If a freeze and the following unfreeze are both applied within one low phase, `out_val[i]` is identical to `div_cur[i]` throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock that drives the dividers |
| rst_n | input | 1 | Active-low asynchronous master reset |
| div_cur | input | N_CH | Current level of each divided clock |
| div_nxt | input | N_CH | Level each divided clock will have in the next cycle |
| run_req | input | N_CH | Asynchronous run request per channel, 1 = run, 0 = freeze |
| out_val | output | N_CH | Gated clock value per channel, to the pad data input |
| out_oe | output | N_CH | Pad drive enable per channel, 0 = high impedance |

## Verification
`out_val` is combinational from `div_cur`, so every output result is due in the same fast cycle as its source level. The monitor samples it at the falling edge of `clk`, after the divider and request drivers have settled. A run request driven in cycle k reaches the gate after two synchronizer flops. The reference model applies it at the first edge, from k+3 on, that closes a cycle whose window was open. The model keeps a shift history of the requests it drove, so the expected item for each cycle is pushed before the monitor compares it. `out_oe` reacts to reset within the same cycle, and the bench checks it a fraction of a nanosecond after reset falls.

// File: rtl/frzgate_pkg.sv
`timescale 1ns/1ps
package frzgate_pkg;

  // The gate may change state only when the clock is low now and stays low next.
  function automatic logic low_window(input logic cur, input logic nxt);
    return (!cur) && (!nxt);
  endfunction

  // Gated clock level: source passes only while the channel runs.
  function automatic logic gate_level(input logic cur, input logic run_en);
    return cur & run_en;
  endfunction

endpackage

// File: rtl/frz_sync.sv
`timescale 1ns/1ps
module frz_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/frz_cell.sv
`timescale 1ns/1ps
module frz_cell
  import frzgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic nxt,
  input  logic run_sync,
  output logic run_en,
  output logic win,
  output logic gated
);
  assign win = low_window(cur, nxt);

  // Enable register: reset to running, loads only inside a safe low window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_en <= 1'b1;
    else if (win) run_en <= run_sync;
  end

  assign gated = gate_level(cur, run_en);
endmodule

// File: rtl/frz_pad.sv
`timescale 1ns/1ps
module frz_pad (
  input  logic rst_n,
  input  logic d,
  output logic val,
  output logic oe
);
  assign val = d;
  assign oe  = rst_n;
endmodule

// File: rtl/clk_freeze_gate.sv
`timescale 1ns/1ps
module clk_freeze_gate #(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] div_cur,
  input  logic [N_CH-1:0] div_nxt,
  input  logic [N_CH-1:0] run_req,
  output logic [N_CH-1:0] out_val,
  output logic [N_CH-1:0] out_oe
);
  localparam int LAST_CH = N_CH - 1;

  logic [LAST_CH:0] run_sync_vec;
  logic [LAST_CH:0] en_vec;
  logic [LAST_CH:0] win_vec;
  logic [LAST_CH:0] gated_vec;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      frz_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run_req[i]),
        .q     (run_sync_vec[i])
      );
      frz_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (div_cur[i]),
        .nxt      (div_nxt[i]),
        .run_sync (run_sync_vec[i]),
        .run_en   (en_vec[i]),
        .win      (win_vec[i]),
        .gated    (gated_vec[i])
      );
      frz_pad u_pad (
        .rst_n (rst_n),
        .d     (gated_vec[i]),
        .val   (out_val[i]),
        .oe    (out_oe[i])
      );
    end
  endgenerate
endmodule

// File: rtl/clk_freeze_gate_chk.sv
`timescale 1ns/1ps
module clk_freeze_gate_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] div_cur,
  input logic [N_CH-1:0] en_vec,
  input logic [N_CH-1:0] win_vec,
  input logic [N_CH-1:0] gated_vec
);
  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_a
      p_en_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_vec[i]) |-> $past(win_vec[i]));
      p_fall_natural_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gated_vec[i]) |-> $fell(div_cur[i]));
      p_high_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gated_vec[i]) && div_cur[i]) |-> gated_vec[i]);
      p_rise_natural_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gated_vec[i]) |-> $rose(div_cur[i]));
    end
  endgenerate

  p_running_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&en_vec));
endmodule

bind clk_freeze_gate clk_freeze_gate_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_cur   (div_cur),
  .en_vec    (en_vec),
  .win_vec   (win_vec),
  .gated_vec (gated_vec)
);

// File: tb/clk_freeze_gate_tb.sv
`timescale 1ns/1ps
module clk_freeze_gate_tb;
  localparam int N  = 4;
  localparam int SS = 2;
  localparam int HD = SS + 1;
  localparam int RAT [N] = '{4, 6, 8, 12};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] div_cur, div_nxt, run_req, out_val, out_oe;
  int cnt [N];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  string tag = "R7";

  typedef struct { int ch; logic [1:0] exp; string t; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  clk_freeze_gate #(.N_CH(N), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_cur(div_cur), .div_nxt(div_nxt),
    .run_req(run_req), .out_val(out_val), .out_oe(out_oe)
  );

  function automatic logic lvl(int ch, int k);
    return ((k % RAT[ch]) >= RAT[ch] / 2);
  endfunction

  task automatic chk(bit ok, string t, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%b exp=%b", t, what, act, exp);
    end
  endtask

  // Divider model: levels change 1 ns after each rising edge.
  initial begin
    for (int c = 0; c < N; c++) begin
      cnt[c] = 0; div_cur[c] = lvl(c, 0); div_nxt[c] = lvl(c, 1);
    end
    forever begin
      @(posedge clk); #1;
      for (int c = 0; c < N; c++) begin
        cnt[c] = (cnt[c] + 1) % RAT[c];
        div_cur[c] = lvl(c, cnt[c]);
        div_nxt[c] = lvl(c, cnt[c] + 1);
      end
    end
  end

  // Reference model: pushes one expected {oe,val} item per channel per cycle.
  logic hist [N][HD+1];
  logic exp_en [N];
  logic win_prev [N];
  initial begin
    for (int c = 0; c < N; c++) begin
      for (int k = 0; k <= HD; k++) hist[c][k] = 1'b1;
      exp_en[c] = 1'b1; win_prev[c] = 1'b0;
    end
    forever begin
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
        item_t it;
        for (int k = HD; k > 0; k--) hist[c][k] = hist[c][k-1];
        hist[c][0] = run_req[c];
        if (!rst_n) begin
          for (int k = 1; k <= HD; k++) hist[c][k] = 1'b1;
          exp_en[c] = 1'b1;
        end else if (win_prev[c]) begin
          exp_en[c] = hist[c][HD];
        end
        it.ch = c;
        it.exp = {rst_n, div_cur[c] & exp_en[c]};
        it.t = tag;
        sbq.push_back(it);
        win_prev[c] = rst_n && !div_cur[c] && !div_nxt[c];
      end
    end
  end

  // Monitor: pops expected items and compares them with the pads.
  initial forever begin
    @(negedge clk); #0.5;
    while (sbq.size() > 0) begin
      item_t it;
      logic [1:0] act;
      it = sbq.pop_front();
      act = {out_oe[it.ch], out_val[it.ch]};
      chk(act === it.exp, it.t, $sformatf("scoreboard ch%0d", it.ch), act, it.exp);
    end
  end

  task automatic wait_cnt(int ch, int v);
    do begin @(posedge clk); #2; end while (cnt[ch] != v);
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    int r_out, r_src, mism, high;
    logic po, pc;
    run_req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(out_oe == '0, "R7", "oe in reset", {1'b0, out_oe[0]}, 2'b00);
    @(posedge clk); #1.5; rst_n = 1'b1;
    tag = "R6"; cycles(30);

    // R2: freeze ch2 while its clock is high; the pulse must finish.
    tag = "R2"; wait_cnt(2, 4); run_req[2] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(out_val[2] == 1'b1, "R2", "pulse kept ch2", {1'b0, out_val[2]}, 2'b01);
    end
    cycles(26);

    // R1: ch2 held frozen, ch0 frozen too, divider keeps going.
    tag = "R1"; @(posedge clk); #2; run_req[0] = 1'b0; cycles(6);
    r_out = 0; r_src = 0; po = out_val[2]; pc = div_cur[2];
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      if (out_val[2] && !po) r_out++;
      if (div_cur[2] && !pc) r_src++;
      po = out_val[2]; pc = div_cur[2];
    end
    chk(r_out == 0, "R1", "frozen rises ch2", r_out[1:0], 2'b00);
    chk(r_src >= 4, "R1", "source keeps running ch2", r_src[1:0], 2'b01);

    // R3: unfreeze ch2 in its high phase; first rise lands on cnt 4.
    tag = "R3"; wait_cnt(2, 5); run_req[2] = 1'b1;
    po = 1'b0; pc = 1'b1;
    do begin
      @(negedge clk); #1;
      if (out_val[2] && !po) break;
      po = out_val[2]; pc = div_cur[2];
    end while (1);
    chk(cnt[2] == 4 && !pc, "R3", "first rise at natural edge ch2",
        {pc, cnt[2] == 4}, 2'b01);
    @(posedge clk); #2; run_req[0] = 1'b1;

    // R4: once running, every channel follows its source exactly.
    tag = "R4"; cycles(12);
    mism = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); #1;
      if (out_val != div_cur) mism++;
    end
    chk(mism == 0, "R4", "in phase all channels", mism[1:0], 2'b00);

    // R5: freeze ch1 at cnt 1; applied only after the next low window.
    tag = "R5"; wait_cnt(1, 1); run_req[1] = 1'b0;
    high = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); #1; high += int'(out_val[1]); end
    chk(high == 3, "R5", "pulse before window ch1", high[1:0], 2'b11);
    high = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); #1; high += int'(out_val[1]); end
    chk(high == 0, "R5", "frozen after window ch1", high[1:0], 2'b00);
    @(posedge clk); #2; run_req[1] = 1'b1; cycles(20);

    // R8: freeze then unfreeze inside one low phase on ch3 and ch2.
    tag = "R8"; wait_cnt(3, 10); run_req[3] = 1'b0;
    @(posedge clk); #2; run_req[3] = 1'b1;
    mism = 0;
    for (int k = 0; k < 36; k++) begin
      @(negedge clk); #1;
      if (out_val[3] != div_cur[3]) mism++;
    end
    chk(mism == 0, "R8", "ungated waveform ch3", mism[1:0], 2'b00);
    wait_cnt(2, 6); run_req[2] = 1'b0;
    @(posedge clk); #2; run_req[2] = 1'b1;
    mism = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); #1;
      if (out_val[2] != div_cur[2]) mism++;
    end
    chk(mism == 0, "R8", "ungated waveform ch2", mism[1:0], 2'b00);

    // R7: asynchronous reset mid-run while ch0 is frozen.
    tag = "R7"; @(posedge clk); #2; run_req[0] = 1'b0; cycles(12);
    rst_n = 1'b0; #0.2;
    chk(out_oe == '0, "R7", "immediate tristate", {1'b0, |out_oe}, 2'b00);
    run_req[0] = 1'b1; cycles(3);
    @(posedge clk); #1.5; rst_n = 1'b1;
    tag = "R6"; cycles(2);
    mism = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #1;
      if (out_val[0] != div_cur[0] || out_oe != '1) mism++;
    end
    chk(mism == 0, "R6", "running after reset ch0", mism[1:0], 2'b00);
    cycles(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule